// File: doc/BRIEF.md
# Stream-Commanded GPIO Controller

This block is a general-purpose I/O controller that a processor drives entirely through two point-to-point streams. Command words arrive on a slave stream (data, valid, ready). Each word carries an opcode in its three most significant bits and a value or mask in its low bits. The block owns an output register. A command can load it whole, or set, clear or toggle the bits picked by a mask. Other commands return the synchronized input lines or the current output register. Two combined commands return the inputs and update the outputs in the same operation. Reply words leave on a master stream.

A group of low output bits can also be cleared by hardware. Each of the lowest `EC_N` outputs is paired with one bit of a separate edge-clear input vector. When that input shows the selected edge (falling when `EC_RISE` is 0, rising when it is 1), the paired output is forced to 0. When `EC_N` is 0 this feature does not exist. In that case the edge-clear port is one bit wide and is ignored.

Top module: `strm_gpio`

## Requirements
- R1: After a synchronous active-high reset, `gpio_out` is 0, `m_valid` is 0 and `s_ready` is 1.
- R2: Opcode 000 (opcode field = `s_data[DATA_W-1:DATA_W-3]`) loads `s_data[OUT_W-1:0]` into `gpio_out`. The new value is visible in the cycle after the word is accepted. Bits between the value field and the opcode are ignored.
- R3: Opcode 001 sets to 1 every output whose mask bit is 1 and leaves the other outputs unchanged.
- R4: Opcode 010 clears to 0 every output whose mask bit is 1 and leaves the other outputs unchanged.
- R5: Opcode 011 inverts every output whose mask bit is 1 and leaves the other outputs unchanged.
- R6: Opcode 100 produces one reply word holding the synchronized inputs, zero-extended, with `m_valid` high in the cycle after acceptance. The inputs pass through two flops, so a read accepted at the second clock edge after an input change still returns the old value.
- R7: Opcode 101 produces a reply holding the output register as it was when the command was accepted, zero-extended.
- R8: Opcodes 110 and 111 reply with the inputs sampled at acceptance. In the same operation, 110 loads the outputs and 111 toggles the masked outputs.
- R9: Opcodes 000 to 011 produce no reply word.
- R10: While `m_valid` is high and `m_ready` is low, `s_ready` stays low, `m_data` stays stable and no command is consumed.
- R11: For i < `EC_N`, a selected edge on `ec_in[i]` forces `gpio_out[i]` to 0 three clock edges after the input changes. The opposite edge has no effect.
- R12: If an edge clear and a command that writes the same output bit take effect in the same cycle, the bit ends at 0. The command still updates the other bits.
- R13: With no accepted command and no edge clear, `gpio_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | DATA_W | Command word: opcode in top 3 bits, value or mask in low OUT_W bits |
| s_valid | input | 1 | Command word present |
| s_ready | output | 1 | Block can take a command |
| m_data | output | DATA_W | Reply word, zero-extended |
| m_valid | output | 1 | Reply word present |
| m_ready | input | 1 | Downstream takes the reply |
| gpio_in | input | IN_W | Asynchronous input lines |
| gpio_out | output | OUT_W | Output register |
| ec_in | input | max(EC_N,1) | Edge-clear inputs, bit i paired with output i |

## Verification
The update logic is exercised with a long seeded-random mix of all eight opcodes, random masks and random filler between the value field and the opcode. This separates the four update rules from each other and shows that the filler bits do nothing. Inputs change between bursts, which catches replies that return the outputs instead of the inputs, or the post-update outputs instead of the pre-update ones. Directed cases then isolate the rest. An input change followed at once by a read shows the two-flop latency. A stalled reply with a waiting write shows that no command slips through. A falling edge is timed so that its clear lands in the same cycle as a write to that bit, which pins down edge-clear timing and priority. A rising edge checks that the opposite edge is ignored.

// File: rtl/strm_gpio_pkg.sv
package strm_gpio_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_PUT         = 3'b000,
        OPC_SET         = 3'b001,
        OPC_CLR         = 3'b010,
        OPC_FLIP        = 3'b011,
        OPC_GET_IN      = 3'b100,
        OPC_GET_OUT     = 3'b101,
        OPC_GET_IN_PUT  = 3'b110,
        OPC_GET_IN_FLIP = 3'b111
    } opc_e;

    typedef enum logic [1:0] {
        UPD_LOAD,
        UPD_OR,
        UPD_ANDN,
        UPD_XOR
    } upd_e;

    typedef struct packed {
        logic upd_en;   // command changes the output register
        upd_e upd;      // how it changes it
        logic rsp_en;   // command produces a reply
        logic rsp_out;  // reply carries outputs (1) or inputs (0)
    } cmd_dec_t;

    function automatic cmd_dec_t decode_opc(opc_e op);
        cmd_dec_t d;
        d = '{upd_en: 1'b0, upd: UPD_LOAD, rsp_en: 1'b0, rsp_out: 1'b0};
        unique case (op)
            OPC_PUT:         begin d.upd_en = 1'b1; d.upd = UPD_LOAD; end
            OPC_SET:         begin d.upd_en = 1'b1; d.upd = UPD_OR;   end
            OPC_CLR:         begin d.upd_en = 1'b1; d.upd = UPD_ANDN; end
            OPC_FLIP:        begin d.upd_en = 1'b1; d.upd = UPD_XOR;  end
            OPC_GET_IN:      begin d.rsp_en = 1'b1; end
            OPC_GET_OUT:     begin d.rsp_en = 1'b1; d.rsp_out = 1'b1; end
            OPC_GET_IN_PUT:  begin d.rsp_en = 1'b1; d.upd_en = 1'b1; d.upd = UPD_LOAD; end
            OPC_GET_IN_FLIP: begin d.rsp_en = 1'b1; d.upd_en = 1'b1; d.upd = UPD_XOR;  end
            default:         ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sg_edge.sv
module sg_edge #(
    parameter int N    = 1,
    parameter bit RISE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    generate
        if (RISE) begin : g_rise
            assign hit = lvl & ~prev;
        end else begin : g_fall
            assign hit = ~lvl & prev;
        end
    endgenerate
endmodule

// File: rtl/sg_core.sv
module sg_core
    import strm_gpio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 8,
    parameter int IN_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    input  logic [IN_W-1:0]   in_sync,
    input  logic [OUT_W-1:0]  clr_mask,
    output logic [OUT_W-1:0]  out_q
);
    opc_e             op;
    cmd_dec_t         dec;
    logic             accept;
    logic [OUT_W-1:0] arg;
    logic [OUT_W-1:0] upd_val;
    logic [OUT_W-1:0] out_nxt;

    assign op        = opc_e'(cmd_data[DATA_W-1 -: OPC_W]);
    assign arg       = cmd_data[OUT_W-1:0];
    assign dec       = decode_opc(op);
    assign cmd_ready = ~rsp_valid | rsp_ready;
    assign accept    = cmd_valid & cmd_ready;

    always_comb begin
        unique case (dec.upd)
            UPD_LOAD: upd_val = arg;
            UPD_OR:   upd_val = out_q | arg;
            UPD_ANDN: upd_val = out_q & ~arg;
            UPD_XOR:  upd_val = out_q ^ arg;
            default:  upd_val = out_q;
        endcase
        out_nxt = (accept && dec.upd_en) ? upd_val : out_q;
        out_nxt = out_nxt & ~clr_mask;  // hardware clear has priority
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else if (accept && dec.rsp_en) begin
            rsp_valid <= 1'b1;
            rsp_data  <= dec.rsp_out ? DATA_W'(out_q) : DATA_W'(in_sync);
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/strm_gpio.sv
module strm_gpio
    import strm_gpio_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int OUT_W   = 8,
    parameter int IN_W    = 8,
    parameter int EC_N    = 0,
    parameter bit EC_RISE = 1'b0,
    localparam int EC_W   = (EC_N > 0) ? EC_N : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    input  logic [IN_W-1:0]   gpio_in,
    output logic [OUT_W-1:0]  gpio_out,
    input  logic [EC_W-1:0]   ec_in
);
    logic [IN_W-1:0]  in_sync;
    logic [OUT_W-1:0] clr_mask;

    sg_sync #(.W(IN_W)) u_in_sync (
        .clk (clk),
        .rst (rst),
        .d   (gpio_in),
        .q   (in_sync)
    );

    generate
        if (EC_N > 0) begin : g_ec
            logic [EC_N-1:0] ec_sync;
            logic [EC_N-1:0] ec_hit;

            sg_sync #(.W(EC_N)) u_ec_sync (
                .clk (clk),
                .rst (rst),
                .d   (ec_in),
                .q   (ec_sync)
            );

            sg_edge #(.N(EC_N), .RISE(EC_RISE)) u_ec_edge (
                .clk (clk),
                .rst (rst),
                .lvl (ec_sync),
                .hit (ec_hit)
            );

            assign clr_mask = OUT_W'(ec_hit);
        end else begin : g_no_ec
            logic unused_ec;
            assign unused_ec = ^ec_in;
            assign clr_mask  = '0;
        end
    endgenerate

    sg_core #(.DATA_W(DATA_W), .OUT_W(OUT_W), .IN_W(IN_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd_data  (s_data),
        .cmd_valid (s_valid),
        .cmd_ready (s_ready),
        .rsp_data  (m_data),
        .rsp_valid (m_valid),
        .rsp_ready (m_ready),
        .in_sync   (in_sync),
        .clr_mask  (clr_mask),
        .out_q     (gpio_out)
    );
endmodule

// File: rtl/strm_gpio_chk.sv
module strm_gpio_chk #(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] s_data,
    input logic              s_valid,
    input logic              s_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_ready,
    input logic [OUT_W-1:0]  gpio_out,
    input logic [OUT_W-1:0]  clr_mask
);
    logic             acc;
    logic [2:0]       opc;
    logic [OUT_W-1:0] msk;

    assign acc = s_valid & s_ready;
    assign opc = s_data[DATA_W-1 -: 3];
    assign msk = s_data[OUT_W-1:0];

    // R3: masked bits end up set unless a hardware clear hits them
    a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
        (acc && opc == 3'b001) |=>
        ((gpio_out & $past(msk) & ~$past(clr_mask)) == ($past(msk) & ~$past(clr_mask))));

    // R4: masked bits end up cleared
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (acc && opc == 3'b010) |=> ((gpio_out & $past(msk)) == '0));

    // R6: every read-type command yields a reply the next cycle
    a_r6_reply_follows: assert property (@(posedge clk) disable iff (rst)
        (acc && opc[2]) |=> m_valid);

    // R9: write-only commands leave no reply pending
    a_r9_no_reply: assert property (@(posedge clk) disable iff (rst)
        (acc && !opc[2]) |=> !m_valid);

    // R10: stalled reply blocks commands and holds its data
    a_r10_block_cmd: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |-> !s_ready);

    a_r10_hold_reply: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R12: an edge clear always leaves its bit at 0
    a_r12_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((gpio_out & $past(clr_mask)) == '0));

    // R13: no command and no clear means no output change
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!acc && clr_mask == '0) |=> $stable(gpio_out));
endmodule

bind strm_gpio strm_gpio_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .s_data   (s_data),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .m_data   (m_data),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .gpio_out (gpio_out),
    .clr_mask (clr_mask)
);

// File: tb/strm_gpio_bench.sv
`timescale 1ns/1ps
module strm_gpio_bench;
    localparam int DATA_W = 16;
    localparam int OUT_W  = 8;
    localparam int IN_W   = 8;
    localparam int EC_N   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [DATA_W-1:0] m_data;
    logic              m_valid;
    logic              m_ready = 1'b1;
    logic [IN_W-1:0]   gpio_in = '0;
    logic [OUT_W-1:0]  gpio_out;
    logic [EC_N-1:0]   ec_in = '1;

    int n_run  = 0;
    int n_fail = 0;
    logic [OUT_W-1:0] exp_out = '0;
    logic [IN_W-1:0]  cur_in  = '0;

    always #2.5 clk = ~clk;

    strm_gpio #(.DATA_W(DATA_W), .OUT_W(OUT_W), .IN_W(IN_W),
                .EC_N(EC_N), .EC_RISE(1'b0)) u_strm_gpio (
        .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid),
        .s_ready(s_ready), .m_data(m_data), .m_valid(m_valid),
        .m_ready(m_ready), .gpio_in(gpio_in), .gpio_out(gpio_out),
        .ec_in(ec_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [OUT_W-1:0] model_out(input logic [2:0] op,
            input logic [OUT_W-1:0] v, input logic [OUT_W-1:0] cur);
        case (op)
            3'd0, 3'd6: return v;
            3'd1:       return cur | v;
            3'd2:       return cur & ~v;
            3'd3, 3'd7: return cur ^ v;
            default:    return cur;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] model_rsp(input logic [2:0] op,
            input logic [IN_W-1:0] ins, input logic [OUT_W-1:0] cur);
        return (op == 3'd5) ? DATA_W'(cur) : DATA_W'(ins);
    endfunction

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    // issue one command, then check outputs and reply one cycle after acceptance
    task automatic send(input logic [2:0] op, input logic [OUT_W-1:0] v,
                        input logic [4:0] junk, input logic [OUT_W-1:0] hwclr);
        logic [DATA_W-1:0] rsp_exp;
        @(negedge clk);
        s_data  = {op, junk, v};
        s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        rsp_exp = model_rsp(op, cur_in, exp_out);
        exp_out = model_out(op, v, exp_out) & ~hwclr;
        @(negedge clk);
        s_valid = 1'b0;
        chk(op_req(op), 32'(gpio_out), 32'(exp_out));
        if (op[2]) begin
            chk(op_req(op), 32'(m_valid), 32'd1);
            chk(op_req(op), 32'(m_data), 32'(rsp_exp));
        end else begin
            chk("R9", 32'(m_valid), 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        logic [DATA_W-1:0] held;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", 32'(gpio_out), 32'd0);
        chk("R1", 32'(m_valid), 32'd0);
        chk("R1", 32'(s_ready), 32'd1);

        // R2 with filler in the middle bits, then R3/R4/R5 directed
        send(3'd0, 8'h3C, 5'h1F, '0);
        send(3'd1, 8'h81, 5'h0A, '0);
        send(3'd2, 8'h0C, 5'h00, '0);
        send(3'd3, 8'hFF, 5'h15, '0);

        // R6: two-flop latency, then new value visible
        @(negedge clk);
        gpio_in = 8'hA5;
        send(3'd4, '0, '0, '0);     // still the old sample (0)
        cur_in = 8'hA5;
        send(3'd4, '0, '0, '0);
        // R7 and R8 directed
        send(3'd5, '0, '0, '0);
        send(3'd6, 8'h5A, 5'h03, '0);
        send(3'd7, 8'h0F, '0, '0);

        // random mix (R2..R9, R13)
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                gpio_in = IN_W'($urandom());
                repeat (3) @(negedge clk);
                cur_in = gpio_in;
                chk("R13", 32'(gpio_out), 32'(exp_out));
            end
            send(3'($urandom()), OUT_W'($urandom()), 5'($urandom()), '0);
        end

        // R10: stalled reply blocks a pending write
        @(negedge clk);
        m_ready = 1'b0;
        send(3'd4, '0, '0, '0);
        held = m_data;
        s_data  = {3'd0, 5'd0, 8'h5A};
        s_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10", 32'(s_ready), 32'd0);
            chk("R10", 32'(m_data), 32'(held));
            chk("R10", 32'(m_valid), 32'd1);
            chk("R10", 32'(gpio_out), 32'(exp_out));
        end
        m_ready = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        exp_out = 8'h5A;
        chk("R10", 32'(gpio_out), 32'(exp_out));
        chk("R9", 32'(m_valid), 32'd0);

        // R11: falling edge on ec_in[1] clears output 1 after three edges
        send(3'd0, 8'hFF, '0, '0);
        ec_in[1] = 1'b0;
        @(negedge clk);
        chk("R11", 32'(gpio_out), 32'hFF);
        @(negedge clk);
        chk("R11", 32'(gpio_out), 32'hFF);
        @(negedge clk);
        exp_out = 8'hFD;
        chk("R11", 32'(gpio_out), 32'(exp_out));
        ec_in[1] = 1'b1;                 // rising edge: no effect
        repeat (5) @(negedge clk);
        chk("R11", 32'(gpio_out), 32'(exp_out));
        send(3'd1, 8'h02, '0, '0);        // bit back on after rising edge

        // R12: write of bit 0 lands in the same cycle as its edge clear
        send(3'd0, 8'h01, '0, '0);
        ec_in[0] = 1'b0;
        @(negedge clk);
        send(3'd0, 8'h0F, '0, 8'h01);     // expect 0x0E
        chk("R12", 32'(gpio_out), 32'h0E);
        repeat (3) @(negedge clk);
        chk("R13", 32'(gpio_out), 32'h0E);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule